// File: doc/BRIEF.md
# ADC Conversion Sequencer and Configurable-Width Result Bus

This block is the digital control and readout side of an 18-bit successive-approximation converter. A falling edge on the active-low conversion-start pin captures a sample, raises `busy` for a fixed number of clock cycles and then stores the captured value as the new result. The analog conversion is replaced by a test input, `sample_in`, which is captured when the conversion begins. A separate converter-reset pin aborts any conversion while it is high. When that pin falls, a calibration interval follows and `busy` stays high for its whole length. A power-down pin lets a conversion that is already running finish, and blocks new conversions while it stays high.

The stored result is read from an 18-line parallel bus. Each line has its own output-enable, so the tri-state buffers can sit outside this block. A 2-bit width mode selects how the result is presented: all 18 lines at once, two 16-bit words, three bytes, or nothing (the parallel bus stays quiet). In the narrow modes the low lines act as control inputs and this block never drives them. Line 0 carries the output-format select, line 1 carries address bit A0, and in byte mode line 2 carries A1. These inputs reach the block on the separate ports `fmt_twos`, `addr_a0` and `addr_a1`. The bus drives only while both chip-select and read are low.

The pins `cnv_start_n`, `cal_reset` and `pwr_down` are asynchronous. Each one passes through a two-flop synchroniser, and edges are detected on the synchronised level. The chip-select, read, mode, address and format inputs act combinationally on the bus. No handshake exists at either edge of the block: a result stays readable until the next conversion that completes normally, so the reader never applies back-pressure.

Top module: `adc_ctrl_readout`

## Requirements
- R1: A falling edge on `cnv_start_n` seen while idle makes `busy` go high after the third rising clock edge that follows the change. `busy` then stays high for exactly CONV_CYCLES cycles (default 20). `sample_in` is captured on the edge where `busy` rises. The stored result takes that captured value on the edge where `busy` falls, and it changes at no other time except reset by `rst_n`.
- R2: While the synchronised `cal_reset` is high, the block returns to idle with `busy` low. Any conversion in progress is dropped and the stored result keeps its previous value.
- R3: The falling edge of `cal_reset` starts a calibration interval in which `busy` is high for exactly CAL_CYCLES cycles (default 64). Conversion-start edges during calibration are ignored and leave the result unchanged.
- R4: Raising `pwr_down` during a conversion does not stop it: the conversion completes and updates the result. While `pwr_down` is high and the block is idle, conversion-start edges are ignored, so `busy` stays low and the result is unchanged.
- R5: If `cs_n` or `rd_n` is high, all 18 bits of `data_oe` are 0.
- R6: In mode 0 (`bus_mode`=0), with `cs_n` and `rd_n` both low, all 18 lines are enabled and line i carries result bit i. The format select has no effect in this mode.
- R7: In mode 1, lines 0 and 1 are never enabled and lines 2..17 are enabled. With `addr_a0`=0, line i carries formatted result bit i. With `addr_a0`=1, lines 2 and 3 carry result bits 0 and 1 and lines 4..17 drive 0.
- R8: In mode 2, lines 0..9 are never enabled and lines 10..17 are enabled. The value depends on {`addr_a0`,`addr_a1`}. With 00, lines 10..17 carry formatted bits 10..17. With 01, they carry bits 2..9. With 10, lines 10..11 carry bits 0..1 and lines 12..17 drive 0. With 11, lines 10..15 drive 0 and lines 16..17 carry bits 0..1.
- R9: In mode 3 no data line is enabled.
- R10: After `rst_n` is released, `busy` is low and the stored result is 0.
- R11: In modes 1 and 2 with `fmt_twos`=1, result bit 17 is inverted wherever it appears on the bus. Every other bit is unchanged. With `fmt_twos`=0 the bits appear as stored.
- R12: Conversion-start edges that arrive while a conversion is running are ignored. `busy` keeps its single CONV_CYCLES-long pulse and the result is the sample captured at the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset of the whole block |
| cnv_start_n | input | 1 | Asynchronous conversion start, active on its falling edge |
| cal_reset | input | 1 | Asynchronous converter reset; its falling edge starts calibration |
| pwr_down | input | 1 | Asynchronous power-down request |
| cs_n | input | 1 | Active-low chip select for the bus |
| rd_n | input | 1 | Active-low read enable for the bus |
| bus_mode | input | 2 | Bus width mode: 0 full, 1 word, 2 byte, 3 parallel off |
| fmt_twos | input | 1 | Format select shared with line 0: 1 selects two's complement |
| addr_a0 | input | 1 | Address bit shared with line 1 |
| addr_a1 | input | 1 | Address bit shared with line 2, used in byte mode |
| sample_in | input | 18 | Stand-in for the analog sample, captured at conversion start |
| busy | output | 1 | High during a conversion or calibration |
| data_out | output | 18 | Values for the data lines |
| data_oe | output | 18 | Per-line output enable |

## Verification
The hardest case to reach is an edge that lands while the sequencer is busy with something else. One such case is a conversion aborted part-way while a different sample waits in the capture register. Others are a start edge during calibration, and a start edge just after power-down has been raised under a running conversion. The stimulus counts clock cycles from each start pulse so the interfering pulse arrives well inside the busy window. It also changes `sample_in` after capture, so a wrongly restarted or wrongly committed conversion leaves a visible wrong value on the full-width bus. The behavioural model is compared on every cycle and catches any shift in the busy window.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int unsigned RES_W  = 18;
  localparam int unsigned WORD_LO = 2;   // first line driven in word mode
  localparam int unsigned BYTE_LO = 10;  // first line driven in byte mode
  localparam int unsigned BYTE_W  = RES_W - BYTE_LO;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_CAL  = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    BUS_FULL = 2'd0,
    BUS_WORD = 2'd1,
    BUS_BYTE = 2'd2,
    BUS_OFF  = 2'd3
  } bus_mode_t;

  typedef logic [RES_W-1:0] result_t;

  // two's complement view: only the top bit flips
  function automatic result_t apply_format(input result_t r, input logic twos);
    result_t f;
    f = r;
    if (twos) f[RES_W-1] = ~r[RES_W-1];
    return f;
  endfunction

endpackage

// File: rtl/adc_sync_chain.sv
module adc_sync_chain #(
  parameter int unsigned     W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_lvl
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= async_in[g];
        stab_q <= meta_q;
      end
    end

    assign sync_lvl[g] = stab_q;
  end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_rd_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 20,
  parameter int unsigned CAL_CYCLES  = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cnv_lvl,    // synchronised, active-low start
  input  logic    rst_lvl,    // synchronised converter reset
  input  logic    pd_lvl,     // synchronised power-down
  input  result_t sample_in,
  output logic    busy,
  output result_t result
);

  localparam int unsigned CNT_MAX = (CONV_CYCLES > CAL_CYCLES) ? CONV_CYCLES : CAL_CYCLES;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_CYCLES);
  localparam logic [CNT_W-1:0] CAL_LOAD  = CNT_W'(CAL_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  result_t          hold_q;
  result_t          result_q;
  logic             cnv_prev_q;
  logic             rst_prev_q;

  logic start_fall;
  logic cal_fall;
  logic last_cycle;

  // third stage: previous synchronised level, for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_prev_q <= 1'b1;
      rst_prev_q <= 1'b0;
    end else begin
      cnv_prev_q <= cnv_lvl;
      rst_prev_q <= rst_lvl;
    end
  end

  assign start_fall = cnv_prev_q & ~cnv_lvl;
  assign cal_fall   = rst_prev_q & ~rst_lvl;
  assign last_cycle = (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      hold_q   <= '0;
      result_q <= '0;
    end else if (rst_lvl) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else if (cal_fall) begin
      state_q <= SEQ_CAL;
      cnt_q   <= CAL_LOAD;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_fall && !pd_lvl) begin
            state_q <= SEQ_CONV;
            cnt_q   <= CONV_LOAD;
            hold_q  <= sample_in;
          end
        end
        SEQ_CONV: begin
          if (last_cycle) begin
            state_q  <= SEQ_IDLE;
            cnt_q    <= '0;
            result_q <= hold_q;
          end else begin
            cnt_q <= cnt_q - CNT_LAST;
          end
        end
        SEQ_CAL: begin
          if (last_cycle) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q - CNT_LAST;
          end
        end
        default: begin
          state_q <= SEQ_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign busy   = (state_q != SEQ_IDLE);
  assign result = result_q;

endmodule

// File: rtl/adc_bus_mux.sv
module adc_bus_mux
  import adc_rd_pkg::*;
(
  input  result_t    result,
  input  logic [1:0] bus_mode,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       fmt_twos,
  input  logic       addr_a0,
  input  logic       addr_a1,
  output result_t    data_out,
  output result_t    data_oe
);

  result_t   fmt_res;
  bus_mode_t mode;
  logic      bus_on;

  assign fmt_res = apply_format(result, fmt_twos);
  assign mode    = bus_mode_t'(bus_mode);
  assign bus_on  = ~cs_n & ~rd_n;

  always_comb begin
    data_out = '0;
    data_oe  = '0;
    if (bus_on) begin
      unique case (mode)
        BUS_FULL: begin
          data_oe  = '1;
          data_out = result;
        end
        BUS_WORD: begin
          data_oe[RES_W-1:WORD_LO] = '1;
          if (!addr_a0) data_out[RES_W-1:WORD_LO] = fmt_res[RES_W-1:WORD_LO];
          else          data_out[WORD_LO+1:WORD_LO] = fmt_res[1:0];
        end
        BUS_BYTE: begin
          data_oe[RES_W-1:BYTE_LO] = '1;
          unique case ({addr_a0, addr_a1})
            2'b00: data_out[RES_W-1:BYTE_LO] = fmt_res[RES_W-1:BYTE_LO];
            2'b01: data_out[RES_W-1:BYTE_LO] = fmt_res[BYTE_LO-1:WORD_LO];
            2'b10: data_out[BYTE_LO+1:BYTE_LO] = fmt_res[1:0];
            default: data_out[RES_W-1:RES_W-2] = fmt_res[1:0];
          endcase
        end
        default: begin
          data_oe  = '0;
          data_out = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_ctrl_readout.sv
module adc_ctrl_readout
  import adc_rd_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 20,
  parameter int unsigned CAL_CYCLES  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_start_n,
  input  logic             cal_reset,
  input  logic             pwr_down,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic [1:0]       bus_mode,
  input  logic             fmt_twos,
  input  logic             addr_a0,
  input  logic             addr_a1,
  input  logic [RES_W-1:0] sample_in,
  output logic             busy,
  output logic [RES_W-1:0] data_out,
  output logic [RES_W-1:0] data_oe
);

  localparam int unsigned N_ASYNC = 3;
  // bit 0 start (idles high), bit 1 converter reset, bit 2 power-down
  localparam logic [N_ASYNC-1:0] ASYNC_RST = 3'b001;

  logic [N_ASYNC-1:0] sync_lvl;
  logic    cnv_lvl;
  logic    rst_lvl;
  logic    pd_lvl;
  result_t result;

  adc_sync_chain #(
    .W       (N_ASYNC),
    .RST_VAL (ASYNC_RST)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({pwr_down, cal_reset, cnv_start_n}),
    .sync_lvl (sync_lvl)
  );

  assign cnv_lvl = sync_lvl[0];
  assign rst_lvl = sync_lvl[1];
  assign pd_lvl  = sync_lvl[2];

  adc_conv_seq #(
    .CONV_CYCLES (CONV_CYCLES),
    .CAL_CYCLES  (CAL_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv_lvl   (cnv_lvl),
    .rst_lvl   (rst_lvl),
    .pd_lvl    (pd_lvl),
    .sample_in (sample_in),
    .busy      (busy),
    .result    (result)
  );

  adc_bus_mux u_bus (
    .result   (result),
    .bus_mode (bus_mode),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .fmt_twos (fmt_twos),
    .addr_a0  (addr_a0),
    .addr_a1  (addr_a1),
    .data_out (data_out),
    .data_oe  (data_oe)
  );

endmodule

// File: rtl/adc_ctrl_checker.sv
module adc_ctrl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        rd_n,
  input logic [1:0]  bus_mode,
  input logic        busy,
  input logic        rst_lvl,
  input logic        pd_lvl,
  input logic [17:0] result,
  input logic [17:0] data_oe
);

  p_bus_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (data_oe == 18'd0));

  p_word_ctrl_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == 2'd1) |-> (data_oe[1:0] == 2'b00));

  p_byte_ctrl_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == 2'd2) |-> (data_oe[9:0] == 10'd0));

  p_parallel_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == 2'd3) |-> (data_oe == 18'd0));

  p_abort_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_lvl) |-> !busy);

  p_pd_blocks_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_lvl && !busy && !rst_lvl && !$past(rst_lvl)) |=> !busy);

  p_result_only_at_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(result));

endmodule

bind adc_ctrl_readout adc_ctrl_checker u_chk (.*);

// File: tb/test_adc_ctrl_readout.sv
module test_adc_ctrl_readout;

  localparam int CONV_N = 20;
  localparam int CAL_N  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnv_start_n = 1'b1;
  logic        cal_reset = 1'b0;
  logic        pwr_down = 1'b0;
  logic        cs_n = 1'b0;
  logic        rd_n = 1'b0;
  logic [1:0]  bus_mode = 2'd0;
  logic        fmt_twos = 1'b0;
  logic        addr_a0 = 1'b0;
  logic        addr_a1 = 1'b0;
  logic [17:0] sample_in = 18'd0;
  logic        busy;
  logic [17:0] data_out;
  logic [17:0] data_oe;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  adc_ctrl_readout i_adc_ctrl_readout (
    .clk (clk), .rst_n (rst_n), .cnv_start_n (cnv_start_n),
    .cal_reset (cal_reset), .pwr_down (pwr_down), .cs_n (cs_n), .rd_n (rd_n),
    .bus_mode (bus_mode), .fmt_twos (fmt_twos), .addr_a0 (addr_a0),
    .addr_a1 (addr_a1), .sample_in (sample_in), .busy (busy),
    .data_out (data_out), .data_oe (data_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [2:0]  m_cnv = 3'b111;   // [0] first stage, [1] second, [2] previous
  logic [2:0]  m_rst = 3'b000;
  logic [1:0]  m_pd  = 2'b00;
  int          m_phase = 0;      // 0 idle, 1 converting, 2 calibrating
  int          m_left = 0;
  logic [17:0] m_hold = '0;
  logic [17:0] m_result = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnv = 3'b111; m_rst = 3'b000; m_pd = 2'b00;
      m_phase = 0; m_left = 0; m_hold = '0; m_result = '0;
    end else begin
      if (m_rst[1]) begin
        m_phase = 0; m_left = 0;
      end else if (m_rst[2] && !m_rst[1]) begin
        m_phase = 2; m_left = CAL_N;
      end else if (m_phase == 0) begin
        if (m_cnv[2] && !m_cnv[1] && !m_pd[1]) begin
          m_phase = 1; m_left = CONV_N; m_hold = sample_in;
        end
      end else if (m_left == 1) begin
        if (m_phase == 1) m_result = m_hold;
        m_phase = 0; m_left = 0;
      end else begin
        m_left = m_left - 1;
      end
      m_cnv = {m_cnv[1], m_cnv[0], cnv_start_n};
      m_rst = {m_rst[1], m_rst[0], cal_reset};
      m_pd  = {m_pd[0], pwr_down};
    end
  end

  function automatic void model_bus(input logic [17:0] r, output logic [17:0] o, output logic [17:0] e);
    logic [17:0] f;
    f = r;
    if (fmt_twos) f[17] = ~r[17];
    o = '0; e = '0;
    for (int i = 0; i < 18; i++) begin
      if (!cs_n && !rd_n) begin
        case (bus_mode)
          2'd0: begin e[i] = 1'b1; o[i] = r[i]; end
          2'd1: if (i >= 2) begin
                  e[i] = 1'b1;
                  if (!addr_a0) o[i] = f[i];
                  else if (i < 4) o[i] = f[i-2];
                end
          2'd2: if (i >= 10) begin
                  e[i] = 1'b1;
                  case ({addr_a0, addr_a1})
                    2'b00: o[i] = f[i];
                    2'b01: o[i] = f[i-8];
                    2'b10: if (i < 12) o[i] = f[i-10];
                    default: if (i >= 16) o[i] = f[i-16];
                  endcase
                end
          default: ;
        endcase
      end
    end
  endfunction

  function automatic string bus_req();
    if (cs_n || rd_n) return "R5";
    case (bus_mode)
      2'd0: return "R6";
      2'd1: return fmt_twos ? "R11" : "R7";
      2'd2: return fmt_twos ? "R11" : "R8";
      default: return "R9";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [17:0] eo, ee;
      check(busy == (m_phase != 0), "R1 busy window", {31'd0, busy}, {31'd0, m_phase != 0});
      model_bus(m_result, eo, ee);
      check(data_oe == ee, bus_req(), {14'd0, data_oe}, {14'd0, ee});
      check((data_out & ee) == (eo & ee), bus_req(), {14'd0, data_out}, {14'd0, eo});
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); cnv_start_n = 1'b0;
    cycles(2); cnv_start_n = 1'b1;
  endtask

  task automatic read_full(output logic [17:0] v);
    bus_mode = 2'd0; cs_n = 1'b0; rd_n = 1'b0; fmt_twos = 1'b0;
    #2 v = data_out;
  endtask

  task automatic count_busy(output int n);
    int guard;
    n = 0; guard = 0;
    while (!busy && guard < 12) begin @(negedge clk); guard++; end
    while (busy && n < 500) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [17:0] v;
    int n;
    bit rose;

    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    read_full(v);
    check(busy == 1'b0, "R10 busy after reset", {31'd0, busy}, 32'd0);
    check(v == 18'd0, "R10 result after reset", {14'd0, v}, 32'd0);

    // plain conversion
    sample_in = 18'h25A3C;
    pulse_start();
    count_busy(n);
    check(n == CONV_N, "R1 conversion length", n, CONV_N);
    read_full(v);
    check(v == 18'h25A3C, "R1 result committed", {14'd0, v}, 32'h25A3C);

    // restart ignored while converting
    sample_in = 18'h1F00F;
    fork
      count_busy(n);
      begin
        pulse_start();
        cycles(3);
        sample_in = 18'h00ABC;
        cycles(4);
        pulse_start();
      end
    join
    check(n == CONV_N, "R12 single busy pulse", n, CONV_N);
    read_full(v);
    check(v == 18'h1F00F, "R12 first sample kept", {14'd0, v}, 32'h1F00F);
    cycles(5);
    check(busy == 1'b0, "R12 no second conversion", {31'd0, busy}, 32'd0);

    // bus sweep, result 0x1F00F (bit17 = 0), then with bit17 = 1
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin
        sample_in = 18'h2C6B5;
        pulse_start();
        count_busy(n);
      end
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 4; a++)
          for (int f = 0; f < 2; f++) begin
            @(negedge clk);
            bus_mode = m[1:0]; addr_a0 = a[1]; addr_a1 = a[0]; fmt_twos = f[0];
          end
    end
    @(negedge clk);
    // result is now 0x2C6B5 = 10_1100_0110_1011_0101
    bus_mode = 2'd1; addr_a0 = 1'b1; fmt_twos = 1'b0; #2;
    check(data_out == 18'b00_0000_0000_0000_0100, "R7 low word", {14'd0, data_out}, 32'h4);
    bus_mode = 2'd1; addr_a0 = 1'b0; fmt_twos = 1'b1; #2;
    check(data_out[17:2] == 16'h31AD, "R11 word inverted msb", {16'd0, data_out[17:2]}, 32'h31AD);
    bus_mode = 2'd2; addr_a0 = 1'b1; addr_a1 = 1'b1; fmt_twos = 1'b0; #2;
    check(data_out == 18'h10000 && data_oe == 18'h3FC00, "R8 low byte upper lanes",
          {14'd0, data_out}, 32'h10000);
    bus_mode = 2'd2; addr_a0 = 1'b0; addr_a1 = 1'b1; #2;
    check(data_out[17:10] == 8'hAD, "R8 mid byte", {24'd0, data_out[17:10]}, 32'hAD);
    bus_mode = 2'd3; #2;
    check(data_oe == 18'd0, "R9 parallel off", {14'd0, data_oe}, 32'd0);
    bus_mode = 2'd0; fmt_twos = 1'b1; cs_n = 1'b1; #2;
    check(data_oe == 18'd0, "R5 chip select high", {14'd0, data_oe}, 32'd0);
    cs_n = 1'b0; #2;
    check(data_out == 18'h2C6B5, "R6 format ignored in full mode", {14'd0, data_out}, 32'h2C6B5);
    fmt_twos = 1'b0;

    // abort by converter reset, then calibration with an ignored start
    sample_in = 18'h0BEEF;
    pulse_start();
    cycles(5);
    cal_reset = 1'b1;
    cycles(5);
    check(busy == 1'b0, "R2 aborted to idle", {31'd0, busy}, 32'd0);
    read_full(v);
    check(v == 18'h2C6B5, "R2 result kept", {14'd0, v}, 32'h2C6B5);
    sample_in = 18'h12345;
    fork
      count_busy(n);
      begin
        cal_reset = 1'b0;
        cycles(12);
        pulse_start();
      end
    join
    check(n == CAL_N, "R3 calibration length", n, CAL_N);
    cycles(3);
    read_full(v);
    check(v == 18'h2C6B5 && !busy, "R3 start ignored in calibration", {14'd0, v}, 32'h2C6B5);

    // power-down lets the running conversion finish, then blocks starts
    sample_in = 18'h3A5A5;
    pulse_start();
    cycles(6);
    pwr_down = 1'b1;
    n = 0;
    while (busy && n < 40) begin @(negedge clk); n++; end
    read_full(v);
    check(v == 18'h3A5A5, "R4 conversion finishes under power-down", {14'd0, v}, 32'h3A5A5);
    sample_in = 18'h01111;
    pulse_start();
    rose = 1'b0;
    for (int k = 0; k < 25; k++) begin @(negedge clk); if (busy) rose = 1'b1; end
    check(!rose, "R4 start ignored while powered down", {31'd0, rose}, 32'd0);
    read_full(v);
    check(v == 18'h3A5A5, "R4 result unchanged", {14'd0, v}, 32'h3A5A5);
    pwr_down = 1'b0;
    cycles(4);
    pulse_start();
    count_busy(n);
    read_full(v);
    check(n == CONV_N && v == 18'h01111, "R4 conversion after power-up", {14'd0, v}, 32'h01111);

    cycles(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule